// File: doc/BRIEF.md
# Multi-Mode Event Counter

This block is a configurable event tally for on-chip debug and profiling. Each cycle it picks what to count. If input selection is off, it counts clock cycles. If input selection is on, it counts one chosen line of an event vector, either every cycle the line is high (level mode) or once per low-to-high transition (edge mode). A window controller can restrict counting to the span between a start event and a stop event. In plain window mode the count restarts from zero at every start. In accumulate mode the count carries over from one window to the next.

The count is compared against a reference value. When an increment reaches the reference, a sticky match flag is set. Optionally the count returns to zero instead of showing the reference. The match flag drives an interrupt request and a halt request, each behind its own enable. A sticky overflow flag records a wrap past the all-ones value. The count, the match flag and the overflow flag each have their own clear input. All outputs are registered, and the reset is synchronous and active high.

Top module: `event_tally`

## Requirements
- R1: After reset the count is zero and the match flag, overflow flag, interrupt and halt outputs are all low.
- R2: With `cfg_count_sel_en` low, free mode (`cfg_window`=0) and `en` high, the count rises by exactly one per clock.
- R3: With `cfg_count_sel_en` high and `cfg_level`=1, the count rises by one in every enabled cycle in which `evt_in[cfg_count_sel]` is high.
- R4: With `cfg_count_sel_en` high and `cfg_level`=0, the count rises by one for each cycle where `evt_in[cfg_count_sel]` is high after being low in the previous cycle.
- R5: While `en` is low (and `cnt_clr` low) the count does not change.
- R6: With `cfg_window`=1 and `cfg_accumulate`=0, counting happens only in cycles after a start (`evt_in[cfg_start_sel]`) and before a stop (`evt_in[cfg_stop_sel]`). Each start cycle loads zero, and the start and stop cycles themselves are not counted.
- R7: With `cfg_window`=1 and `cfg_accumulate`=1, a start cycle keeps the current count, so the totals of successive windows add up.
- R8: When start and stop are both high in the same cycle, the stop takes effect: the window is closed afterwards and the count does not change in that cycle.
- R9: An increment that makes the count equal `cfg_ref` sets `match_flag`. If `cfg_clear_on_match` is 1, the count becomes zero instead of `cfg_ref`.
- R10: `irq` equals `match_flag` AND `cfg_irq_en`, and `halt` equals `match_flag` AND `cfg_halt_en`. Both are registered in the same cycle as the flag.
- R11: An increment from all ones gives a count of zero and sets `ovf_flag`. The flag then stays high until it is cleared.
- R12: `cnt_clr` zeroes the count, `evt_flag_clr` clears only `match_flag`, and `ovf_clr` clears only `ovf_flag`. A flag being set in the same cycle wins over its clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Counting enable |
| cnt_clr | input | 1 | Zero the count |
| evt_flag_clr | input | 1 | Clear the match flag |
| ovf_clr | input | 1 | Clear the overflow flag |
| evt_in | input | NUM_EVT | Event vector |
| cfg_ref | input | CNT_W | Reference value for match |
| cfg_count_sel_en | input | 1 | 1: count the selected event, 0: count cycles |
| cfg_count_sel | input | SEL_W | Index of the counted event |
| cfg_start_sel | input | SEL_W | Index of the start event |
| cfg_stop_sel | input | SEL_W | Index of the stop event |
| cfg_window | input | 1 | Enable start/stop windowing |
| cfg_accumulate | input | 1 | Keep the count across windows |
| cfg_level | input | 1 | 1: level counting, 0: rising-edge counting |
| cfg_clear_on_match | input | 1 | Zero the count on a match |
| cfg_irq_en | input | 1 | Route the match flag to irq |
| cfg_halt_en | input | 1 | Route the match flag to halt |
| count | output | CNT_W | Current count |
| match_flag | output | 1 | Sticky match flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |
| halt | output | 1 | Halt request |

## Verification
A wrong internal state shows up on `count` within one clock. A stale edge register gives an extra or a missing increment on the first pattern bit. A window flag that is stuck open or stuck closed changes the count in the first idle cycle after a stop or a start. The match and overflow logic can only be observed at exact boundaries, so the bench walks the count up to each reference value and across the wrap. It looks at the flags in the cycle just before and the cycle just after the boundary. The interrupt and halt outputs follow a bad flag in the same cycle.

// File: rtl/tally_pkg.sv
package tally_pkg;
  typedef enum logic [1:0] {
    TM_FREE   = 2'd0,
    TM_WINDOW = 2'd1,
    TM_ACCUM  = 2'd2
  } tally_mode_t;

  typedef struct packed {
    logic open;
    logic zero;
  } gate_cmd_t;
endpackage

// File: rtl/evt_tap.sv
module evt_tap #(
  parameter int NUM_EVT = 8,
  localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               sel_en,
  input  logic [SEL_W-1:0]   sel,
  input  logic               level,
  input  logic [SEL_W-1:0]   start_sel,
  input  logic [SEL_W-1:0]   stop_sel,
  output logic               inc,
  output logic               start_hit,
  output logic               stop_hit
);
  logic [NUM_EVT-1:0] prev_q;
  logic [NUM_EVT-1:0] rise;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= evt_in;
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_rise
    assign rise[i] = evt_in[i] & ~prev_q[i];
  end

  always_comb begin
    if (!sel_en)    inc = 1'b1;
    else if (level) inc = evt_in[sel];
    else            inc = rise[sel];
  end

  assign start_hit = evt_in[start_sel];
  assign stop_hit  = evt_in[stop_sel];
endmodule

// File: rtl/win_gate.sv
module win_gate
  import tally_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  tally_mode_t mode,
  input  logic        start_hit,
  input  logic        stop_hit,
  output gate_cmd_t   cmd
);
  logic run_q, run_d;

  always_comb begin
    run_d    = run_q;
    cmd.open = 1'b0;
    cmd.zero = 1'b0;
    if (en) begin
      if (mode == TM_FREE) begin
        cmd.open = 1'b1;
      end else if (stop_hit) begin
        run_d = 1'b0;
      end else if (start_hit) begin
        run_d    = 1'b1;
        cmd.zero = (mode == TM_WINDOW);
      end else begin
        cmd.open = run_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= run_d;
  end
endmodule

// File: rtl/tally_core.sv
module tally_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_clr,
  input  logic             step,
  input  logic             zero,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             clear_on_match,
  input  logic             irq_en,
  input  logic             halt_en,
  input  logic             flag_clr,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             match_flag,
  output logic             ovf_flag,
  output logic             irq,
  output logic             halt
);
  logic [CNT_W-1:0] cnt_q, cnt_d, nxt;
  logic             flag_q, flag_d, ovf_q, ovf_d;
  logic             irq_q, halt_q, live, hit, wrap;

  assign nxt  = cnt_q + CNT_W'(1);
  assign live = step & ~cnt_clr;
  assign hit  = live & (nxt == ref_val);
  assign wrap = live & (cnt_q == '1);

  always_comb begin
    if (cnt_clr || zero)             cnt_d = '0;
    else if (hit && clear_on_match)  cnt_d = '0;
    else if (step)                   cnt_d = nxt;
    else                             cnt_d = cnt_q;
    flag_d = hit  | (flag_q & ~flag_clr);
    ovf_d  = wrap | (ovf_q & ~ovf_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
      ovf_q  <= ovf_d;
      irq_q  <= flag_d & irq_en;
      halt_q <= flag_d & halt_en;
    end
  end

  assign count      = cnt_q;
  assign match_flag = flag_q;
  assign ovf_flag   = ovf_q;
  assign irq        = irq_q;
  assign halt       = halt_q;
endmodule

// File: rtl/event_tally.sv
module event_tally
  import tally_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 8,
  localparam int SEL_W  = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               cnt_clr,
  input  logic               evt_flag_clr,
  input  logic               ovf_clr,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [CNT_W-1:0]   cfg_ref,
  input  logic               cfg_count_sel_en,
  input  logic [SEL_W-1:0]   cfg_count_sel,
  input  logic [SEL_W-1:0]   cfg_start_sel,
  input  logic [SEL_W-1:0]   cfg_stop_sel,
  input  logic               cfg_window,
  input  logic               cfg_accumulate,
  input  logic               cfg_level,
  input  logic               cfg_clear_on_match,
  input  logic               cfg_irq_en,
  input  logic               cfg_halt_en,
  output logic [CNT_W-1:0]   count,
  output logic               match_flag,
  output logic               ovf_flag,
  output logic               irq,
  output logic               halt
);
  tally_mode_t mode;
  gate_cmd_t   cmd;
  logic        inc, start_hit, stop_hit;

  always_comb begin
    if (!cfg_window)         mode = TM_FREE;
    else if (cfg_accumulate) mode = TM_ACCUM;
    else                     mode = TM_WINDOW;
  end

  evt_tap #(.NUM_EVT(NUM_EVT)) u_tap (
    .clk(clk), .rst(rst), .evt_in(evt_in),
    .sel_en(cfg_count_sel_en), .sel(cfg_count_sel), .level(cfg_level),
    .start_sel(cfg_start_sel), .stop_sel(cfg_stop_sel),
    .inc(inc), .start_hit(start_hit), .stop_hit(stop_hit)
  );

  win_gate u_gate (
    .clk(clk), .rst(rst), .en(en), .mode(mode),
    .start_hit(start_hit), .stop_hit(stop_hit), .cmd(cmd)
  );

  tally_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .cnt_clr(cnt_clr),
    .step(cmd.open & inc), .zero(cmd.zero),
    .ref_val(cfg_ref), .clear_on_match(cfg_clear_on_match),
    .irq_en(cfg_irq_en), .halt_en(cfg_halt_en),
    .flag_clr(evt_flag_clr), .ovf_clr(ovf_clr),
    .count(count), .match_flag(match_flag), .ovf_flag(ovf_flag),
    .irq(irq), .halt(halt)
  );
endmodule

// File: rtl/event_tally_chk.sv
module event_tally_chk #(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 8,
  localparam int SEL_W  = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic               cnt_clr,
  input logic               ovf_clr,
  input logic [NUM_EVT-1:0] evt_in,
  input logic [SEL_W-1:0]   cfg_start_sel,
  input logic [SEL_W-1:0]   cfg_stop_sel,
  input logic               cfg_window,
  input logic               cfg_accumulate,
  input logic [CNT_W-1:0]   count,
  input logic               match_flag,
  input logic               ovf_flag,
  input logic               irq,
  input logic               halt
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !match_flag && !ovf_flag && !irq && !halt));

  assert_step_size_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count == $past(count) || count == '0 ||
              count == $past(count) + CNT_W'(1)));

  assert_hold_off_R5: assert property (@(posedge clk) disable iff (rst)
    (!en && !cnt_clr) |=> count == $past(count));

  assert_start_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (en && cfg_window && !cfg_accumulate && !cnt_clr &&
     evt_in[cfg_start_sel] && !evt_in[cfg_stop_sel]) |=> count == '0);

  assert_stop_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (en && cfg_window && !cnt_clr && evt_in[cfg_stop_sel])
      |=> count == $past(count));

  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (irq || halt) |-> match_flag);

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  assert_ovf_on_wrap_R11: assert property (@(posedge clk) disable iff (rst)
    !ovf_flag |=> (!ovf_flag || count == '0));

  assert_clear_count_R12: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> count == '0);
endmodule

bind event_tally event_tally_chk #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u_chk (
  .clk(clk), .rst(rst), .en(en), .cnt_clr(cnt_clr), .ovf_clr(ovf_clr),
  .evt_in(evt_in), .cfg_start_sel(cfg_start_sel), .cfg_stop_sel(cfg_stop_sel),
  .cfg_window(cfg_window), .cfg_accumulate(cfg_accumulate),
  .count(count), .match_flag(match_flag), .ovf_flag(ovf_flag),
  .irq(irq), .halt(halt)
);

// File: tb/sim_event_tally.sv
module sim_event_tally;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 8;
  localparam int NE  = 4;
  localparam int SW  = 2;
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, cnt_clr = 1'b0, evt_flag_clr = 1'b0, ovf_clr = 1'b0;
  logic [NE-1:0] evt_in = '0;
  logic [CW-1:0] cfg_ref = '0;
  logic cfg_count_sel_en = 1'b0;
  logic [SW-1:0] cfg_count_sel = '0, cfg_start_sel = '0, cfg_stop_sel = '0;
  logic cfg_window = 1'b0, cfg_accumulate = 1'b0, cfg_level = 1'b0;
  logic cfg_clear_on_match = 1'b0, cfg_irq_en = 1'b0, cfg_halt_en = 1'b0;
  logic [CW-1:0] count;
  logic match_flag, ovf_flag, irq, halt;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  event_tally #(.CNT_W(CW), .NUM_EVT(NE)) u0 (
    .clk(clk), .rst(rst), .en(en), .cnt_clr(cnt_clr),
    .evt_flag_clr(evt_flag_clr), .ovf_clr(ovf_clr), .evt_in(evt_in),
    .cfg_ref(cfg_ref), .cfg_count_sel_en(cfg_count_sel_en),
    .cfg_count_sel(cfg_count_sel), .cfg_start_sel(cfg_start_sel),
    .cfg_stop_sel(cfg_stop_sel), .cfg_window(cfg_window),
    .cfg_accumulate(cfg_accumulate), .cfg_level(cfg_level),
    .cfg_clear_on_match(cfg_clear_on_match), .cfg_irq_en(cfg_irq_en),
    .cfg_halt_en(cfg_halt_en), .count(count), .match_flag(match_flag),
    .ovf_flag(ovf_flag), .irq(irq), .halt(halt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic zero_count();
    cnt_clr = 1'b1; evt_in = '0; cyc(1); cnt_clr = 1'b0;
  endtask

  task automatic pulse(input logic [NE-1:0] v);
    evt_in = v; cyc(1); evt_in = '0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        fails++;
        $display("FAIL watchdog (all requirements): actual %0d cycles expected < %0d",
                 cycles, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    chk("R1 count", int'(count), 0);
    chk("R1 flags", int'({match_flag, ovf_flag, irq, halt}), 0);

    // R2: plain cycle counting
    en = 1'b1; cfg_ref = 8'd200;
    for (int n = 1; n <= 6; n++) begin
      zero_count(); cyc(n);
      chk("R2 cycle count", int'(count), n);
    end

    // R5: enable low freezes
    en = 1'b0; cyc(3);
    chk("R5 hold", int'(count), 6);
    en = 1'b1;

    // R3 / R4: sweep all 8-bit patterns on event line 2
    cfg_count_sel_en = 1'b1; cfg_count_sel = 2'd2;
    for (int lv = 0; lv < 2; lv++) begin
      cfg_level = lv[0];
      for (int p = 0; p < 256; p++) begin
        logic [7:0] pv;
        int exp;
        pv = p[7:0];
        zero_count();
        for (int i = 0; i < 8; i++) begin
          evt_in = '0; evt_in[2] = pv[i]; cyc(1);
        end
        evt_in = '0;
        exp = lv ? $countones(pv) : $countones(pv & ~(pv << 1));
        chk(lv ? "R3 level count" : "R4 edge count", int'(count), exp);
      end
    end
    cfg_count_sel_en = 1'b0; cfg_level = 1'b0;

    // R6: plain window, start=line0 stop=line1
    cfg_start_sel = 2'd0; cfg_stop_sel = 2'd1;
    zero_count(); cyc(5);
    cfg_window = 1'b1; cyc(3);
    chk("R6 closed window", int'(count), 5);
    pulse(4'b0001);
    chk("R6 start zeroes", int'(count), 0);
    cyc(4);
    chk("R6 counting", int'(count), 4);
    pulse(4'b0001);
    chk("R6 restart zeroes", int'(count), 0);
    cyc(2);
    pulse(4'b0010);
    chk("R6 stop cycle", int'(count), 2);
    cyc(3);
    chk("R6 after stop", int'(count), 2);

    // R7: accumulate across windows
    cfg_accumulate = 1'b1;
    pulse(4'b0001);
    chk("R7 start keeps", int'(count), 2);
    cyc(4); pulse(4'b0010); cyc(2);
    chk("R7 first window", int'(count), 6);
    pulse(4'b0001); cyc(3);
    chk("R7 summed", int'(count), 9);
    en = 1'b0; cyc(2);
    chk("R5 hold in window", int'(count), 9);
    en = 1'b1;

    // R8: simultaneous start and stop
    pulse(4'b0011); cyc(3);
    chk("R8 stop wins running", int'(count), 9);
    pulse(4'b0011); cyc(2);
    chk("R8 stop wins idle", int'(count), 9);
    cfg_window = 1'b0; cfg_accumulate = 1'b0;

    // R9 / R10: match without clear
    evt_flag_clr = 1'b1; zero_count(); evt_flag_clr = 1'b0;
    cfg_ref = 8'd6; cfg_irq_en = 1'b1;
    cyc(5);
    chk("R9 no match yet", int'(match_flag), 0);
    cyc(1);
    chk("R9 match flag", int'(match_flag), 1);
    chk("R9 count shows ref", int'(count), 6);
    chk("R10 irq", int'({irq, halt}), 2);
    cfg_irq_en = 1'b0; cfg_halt_en = 1'b1; cyc(1);
    chk("R10 halt", int'({irq, halt}), 1);
    evt_flag_clr = 1'b1; cyc(1); evt_flag_clr = 1'b0;
    chk("R12 flag clear", int'({match_flag, irq, halt}), 0);
    cfg_halt_en = 1'b0;

    // R9: clear-on-match sweep
    cfg_clear_on_match = 1'b1;
    for (int r = 1; r <= 10; r++) begin
      cfg_ref = r[7:0];
      evt_flag_clr = 1'b1; zero_count(); evt_flag_clr = 1'b0;
      cyc(r - 1);
      chk("R9 before ref", int'({match_flag, count}), r - 1);
      cyc(1);
      chk("R9 cleared on match", int'({match_flag, count}), 256);
    end
    cfg_clear_on_match = 1'b0;

    // R11 / R12: overflow
    cfg_ref = 8'd200;
    evt_flag_clr = 1'b1; zero_count(); evt_flag_clr = 1'b0;
    cyc(255);
    chk("R11 at all ones", int'({ovf_flag, count}), 255);
    cyc(1);
    chk("R11 wrap", int'({ovf_flag, count}), 256);
    cyc(5);
    chk("R11 sticky", int'({ovf_flag, count}), 256 + 5);
    evt_flag_clr = 1'b1; cyc(1); evt_flag_clr = 1'b0;
    chk("R12 flag clear keeps ovf", int'({ovf_flag, match_flag}), 2);
    ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
    chk("R12 ovf clear", int'({ovf_flag, count}), 7);
    cnt_clr = 1'b1; cyc(1); cnt_clr = 1'b0;
    chk("R12 count clear", int'(count), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule